// File: doc/BRIEF.md
# PHY Calibration Init Sequencer

This block takes over the bring-up of a multi-gigabit serial PHY from software. After one `start` strobe, it works through a parameter table of up to 48 address/data slots and writes each occupied slot into the PHY register file. The writes go through a request/acknowledge register access port. The sequencer then issues a calibration pulse on PHY register 0x09. Two optional phases follow the pulse:

- **Debug poll.** The sequencer saves the debug registers, switches the PHY into debug mode and polls a completion flag. It then puts the saved debug values back.
- **Offset check.** The sequencer inspects the receiver offset code. If the code sits at either end of its range, it widens the offset range and repeats the calibration.

Amplitude and swing-trim overrides arrive as static inputs and are merged into the table values as they stream out. The table itself is read through an index port: the sequencer drives a slot number and the surrounding logic returns that slot's address and data in the same cycle. All 1 ms waits come from a cycle counter of parameter length.

Top module: `phycal_seq`

## Requirements
- R1: After reset, `done`, `fail` and `reg_req` are low and the sequencer waits for `start`.
- R2: With `cfg_load_tbl` set, slots 0 to TBL_DEPTH-1 are visited in rising index order. A slot whose address and data are both zero is not written. Every other slot is written with its own address and data, apart from the overrides in R5. With `cfg_load_tbl` clear, no slot is written.
- R3: `reg_req` stays high with stable `reg_we`, `reg_addr` and `reg_wdata` until `reg_ack`. It drops only in the cycle after an acknowledge.
- R4: Calibration pulse timing:
  - When `cfg_cal_pulse` or `cfg_dbg_poll` is set, register 0x09 is written twice: first with bit 9 cleared, then with bit 9 set.
  - At least DLY_CYC cycles separate the two writes.
  - The base value is the data of slot 9 if that slot is occupied. Otherwise it is the value of one read of 0x09, made once per run and reused by later pulses.
- R5: Override merge:
  - A trim input of 1 to 7 is used as 8.
  - A coarse amplitude other than 0xFF replaces bits 7:0 of the slot-32 value. A nonzero trim then replaces bits 7:4 of that value.
  - If slot 32 is empty and either override is active, register 0x20 is read and the merged value is written back.
  - A fine amplitude other than 0xFFFF replaces the data of slot 33 and is written to 0x21.
- R6: Debug mode entry, when `cfg_dbg_poll` is set, after the pulse:
  - Registers 0x0D and 0x10 are read and saved.
  - 0x0D is written with bit 6 set.
  - 0x10 is written with bits 9:3 (mask 0x03F8) replaced by 0x03C0.
- R7: Completion poll:
  - Register 0x30 is read until bit 15 is set.
  - Consecutive reads are at least DLY_CYC cycles apart.
  - After POLL_MAX+1 reads without the bit, the sequencer sets `fail`.
  - `fail` stays set until the next `start`.
- R8: After the poll, whether it succeeded or timed out, the saved 0x0D and then the saved 0x10 are written back.
- R9: Offset check, when `cfg_ofs_fix` is set:
  - Register 0x1F and then 0x0B are read.
  - If bits 4:1 of 0x1F are all zeros or all ones, and bits 3:2 of 0x0B are not 3, 0x0B is written with that field plus one and all other bits kept. The pulse phase (and debug phase, if enabled) then repeats.
  - Otherwise the run ends.
- R10: `done` is high for exactly one cycle at the end of each run, with no register request open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run (sampled when idle) |
| cfg_load_tbl | input | 1 | Stream the parameter table |
| cfg_cal_pulse | input | 1 | Issue the calibration pulse |
| cfg_dbg_poll | input | 1 | Pulse plus debug-mode poll with save/restore |
| cfg_ofs_fix | input | 1 | Check offset code and retry with wider range |
| trim_fuse | input | 4 | Swing-trim value from fuses |
| amp_coarse | input | 8 | Coarse amplitude override (0xFF = none) |
| amp_fine | input | 16 | Fine amplitude override (0xFFFF = none) |
| tbl_idx | output | 6 | Table slot being looked up |
| tbl_addr | input | 6 | Address stored in the slot |
| tbl_data | input | 16 | Data stored in the slot |
| reg_req | output | 1 | Register access request |
| reg_we | output | 1 | 1 = write, 0 = read |
| reg_addr | output | 6 | PHY register address |
| reg_wdata | output | 16 | Write data |
| reg_ack | input | 1 | Access complete; read data valid |
| reg_rdata | input | 16 | Read data |
| done | output | 1 | One-cycle end-of-run pulse |
| fail | output | 1 | Sticky poll-timeout flag |

## Verification
The bound assertions run on every cycle and check four things:
- the request stays held until acknowledged and drops only after an acknowledge;
- `done` is a single-cycle pulse issued only while the port is quiet;
- `fail` rises only right after a completion-flag read returned bit 15 clear;
- at least DLY_CYC cycles separate the two calibration writes.

Other behaviours can only be shown by the bench's scenarios against its register model. These are:
- the exact order and values of every write, including skipped slots and the override merge;
- that 0x09 is read only once when slot 9 is empty;
- the number of completion-flag reads before a timeout;
- the restored debug values;
- the number of range-widening retries.

// File: rtl/phycal_pkg.sv
package phycal_pkg;

  localparam int AW = 6;
  localparam int DW = 16;

  localparam logic [AW-1:0] A_CAL  = 6'h09;
  localparam logic [AW-1:0] A_RNG  = 6'h0B;
  localparam logic [AW-1:0] A_DBG0 = 6'h0D;
  localparam logic [AW-1:0] A_DBG1 = 6'h10;
  localparam logic [AW-1:0] A_CODE = 6'h1F;
  localparam logic [AW-1:0] A_AMP  = 6'h20;
  localparam logic [AW-1:0] A_FINE = 6'h21;
  localparam logic [AW-1:0] A_POLL = 6'h30;

  localparam logic [DW-1:0] CAL_BIT    = 16'h0200;
  localparam logic [DW-1:0] DBG0_SET   = 16'h0040;
  localparam logic [DW-1:0] DBG1_MASK  = 16'h03F8;
  localparam logic [DW-1:0] DBG1_VALUE = 16'h03C0;

  typedef enum logic [4:0] {
    S_IDLE, S_TBL, S_TBL_WR, S_TBL_RD, S_TBL_RMW,
    S_TOG, S_TOG_RD, S_TOG_LO, S_TOG_WAIT, S_TOG_HI,
    S_DBG_RD0, S_DBG_RD1, S_DBG_WR0, S_DBG_WR1,
    S_POLL_RD, S_POLL_WAIT, S_RST0, S_RST1,
    S_OFS_RDC, S_OFS_RDR, S_OFS_WR, S_FIN
  } seq_st_e;

  // Trim values 1..7 are lifted to 8; 0 and 8..15 pass through.
  function automatic logic [3:0] trim_lift(input logic [3:0] t);
    return ((t != 4'd0) && (t < 4'd8)) ? 4'd8 : t;
  endfunction

  function automatic logic [DW-1:0] amp_merge(input logic [DW-1:0] base,
                                              input logic [7:0]    coarse,
                                              input logic [3:0]    trim);
    logic [DW-1:0] v;
    logic [3:0]    te;
    v  = base;
    te = trim_lift(trim);
    if (coarse != 8'hFF) v[7:0] = coarse;
    if (te != 4'd0)      v[7:4] = te;
    return v;
  endfunction

endpackage

// File: rtl/phycal_xact.sv
module phycal_xact #(
  parameter int AW = 6,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic          go_we,
  input  logic [AW-1:0] go_addr,
  input  logic [DW-1:0] go_wdata,
  input  logic          reg_ack,
  output logic          reg_req,
  output logic          reg_we,
  output logic [AW-1:0] reg_addr,
  output logic [DW-1:0] reg_wdata,
  output logic          xdone
);

  logic          req_q, req_d;
  logic          we_q, we_d;
  logic [AW-1:0] addr_q, addr_d;
  logic [DW-1:0] wdata_q, wdata_d;
  logic          load;

  always_comb begin
    load    = go && !req_q;
    req_d   = req_q;
    we_d    = we_q;
    addr_d  = addr_q;
    wdata_d = wdata_q;
    if (load) begin
      req_d   = 1'b1;
      we_d    = go_we;
      addr_d  = go_addr;
      wdata_d = go_wdata;
    end else if (req_q && reg_ack) begin
      req_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q   <= 1'b0;
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      req_q <= req_d;
      if (load) begin
        we_q    <= we_d;
        addr_q  <= addr_d;
        wdata_q <= wdata_d;
      end
    end
  end

  assign reg_req   = req_q;
  assign reg_we    = we_q;
  assign reg_addr  = addr_q;
  assign reg_wdata = wdata_q;
  assign xdone     = req_q && reg_ack;

endmodule

// File: rtl/phycal_timer.sv
module phycal_timer #(
  parameter int CYC = 50000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  output logic busy,
  output logic expire
);

  localparam int CW = (CYC < 2) ? 1 : $clog2(CYC);

  logic          busy_q, busy_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    expire = busy_q && (cnt_q == '0);
    busy_d = busy_q;
    cnt_d  = cnt_q;
    if (go && !busy_q) begin
      busy_d = 1'b1;
      cnt_d  = CW'(CYC - 1);
    end else if (expire) begin
      busy_d = 1'b0;
    end else if (busy_q) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end

  assign busy = busy_q;

endmodule

// File: rtl/phycal_entry.sv
module phycal_entry
  import phycal_pkg::*;
#(
  parameter int IW = 6
) (
  input  logic [IW-1:0] idx,
  input  logic [AW-1:0] ent_addr,
  input  logic [DW-1:0] ent_data,
  input  logic [3:0]    trim_fuse,
  input  logic [7:0]    amp_coarse,
  input  logic [15:0]   amp_fine,
  output logic          wr_need,
  output logic          rmw_need,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data
);

  localparam int SLOT_AMP  = 32;
  localparam int SLOT_FINE = 33;

  logic empty, is_amp, is_fine, amp_ovr, fine_ovr;

  always_comb begin
    empty    = (ent_addr == '0) && (ent_data == '0);
    is_amp   = (idx == IW'(SLOT_AMP));
    is_fine  = (idx == IW'(SLOT_FINE));
    amp_ovr  = (amp_coarse != 8'hFF) || (trim_lift(trim_fuse) != 4'd0);
    fine_ovr = (amp_fine != 16'hFFFF);
    wr_need  = 1'b0;
    rmw_need = 1'b0;
    wr_addr  = ent_addr;
    wr_data  = ent_data;
    if (is_amp && empty && amp_ovr) begin
      rmw_need = 1'b1;
    end else if (is_amp && !empty) begin
      wr_need = 1'b1;
      wr_data = amp_merge(ent_data, amp_coarse, trim_fuse);
    end else if (is_fine && fine_ovr) begin
      wr_need = 1'b1;
      wr_addr = empty ? A_FINE : ent_addr;
      wr_data = amp_fine;
    end else begin
      wr_need = !empty;
    end
  end

endmodule

// File: rtl/phycal_seq.sv
module phycal_seq
  import phycal_pkg::*;
#(
  parameter int TBL_DEPTH = 48,
  parameter int DLY_CYC   = 50000,
  parameter int POLL_MAX  = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        cfg_load_tbl,
  input  logic        cfg_cal_pulse,
  input  logic        cfg_dbg_poll,
  input  logic        cfg_ofs_fix,
  input  logic [3:0]  trim_fuse,
  input  logic [7:0]  amp_coarse,
  input  logic [15:0] amp_fine,
  output logic [5:0]  tbl_idx,
  input  logic [5:0]  tbl_addr,
  input  logic [15:0] tbl_data,
  output logic        reg_req,
  output logic        reg_we,
  output logic [5:0]  reg_addr,
  output logic [15:0] reg_wdata,
  input  logic        reg_ack,
  input  logic [15:0] reg_rdata,
  output logic        done,
  output logic        fail
);

  localparam int IW  = 6;
  localparam int PCW = $clog2(POLL_MAX + 1);
  localparam logic [IW-1:0] CAL_SLOT = IW'(9);
  localparam logic [IW-1:0] LAST_IDX = IW'(TBL_DEPTH);

  seq_st_e        st_q, st_d;
  logic [IW-1:0]  idx_q, idx_d;
  logic [DW-1:0]  base_q, base_d;
  logic           base_ok_q, base_ok_d;
  logic [DW-1:0]  sv0_q, sv0_d, sv1_q, sv1_d;
  logic [DW-1:0]  tmp_q, tmp_d;
  logic [3:0]     code_q, code_d;
  logic [PCW-1:0] pcnt_q, pcnt_d;
  logic           fail_q, fail_d;

  logic          acc, acc_we;
  logic [AW-1:0] acc_addr;
  logic [DW-1:0] acc_wdata;
  logic          x_busy, xdone;
  logic          tmr_go, tmr_busy, tmr_exp, in_wait;
  logic          e_wr, e_rmw;
  logic [AW-1:0] e_addr;
  logic [DW-1:0] e_data;
  logic          tgl_en, slot_full, ofs_pinned;
  seq_st_e       after_tog, after_dbg;

  phycal_entry #(.IW(IW)) u_entry (
    .idx(idx_q), .ent_addr(tbl_addr), .ent_data(tbl_data),
    .trim_fuse(trim_fuse), .amp_coarse(amp_coarse), .amp_fine(amp_fine),
    .wr_need(e_wr), .rmw_need(e_rmw), .wr_addr(e_addr), .wr_data(e_data)
  );

  phycal_xact #(.AW(AW), .DW(DW)) u_xact (
    .clk(clk), .rst_n(rst_n), .go(acc && !x_busy), .go_we(acc_we),
    .go_addr(acc_addr), .go_wdata(acc_wdata), .reg_ack(reg_ack),
    .reg_req(x_busy), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .xdone(xdone)
  );

  phycal_timer #(.CYC(DLY_CYC)) u_tmr (
    .clk(clk), .rst_n(rst_n), .go(tmr_go), .busy(tmr_busy), .expire(tmr_exp)
  );

  assign reg_req   = x_busy;
  assign tgl_en    = cfg_cal_pulse || cfg_dbg_poll;
  assign after_dbg = cfg_ofs_fix ? S_OFS_RDC : S_FIN;
  assign after_tog = cfg_dbg_poll ? S_DBG_RD0 : after_dbg;
  assign slot_full = (tbl_addr != '0) || (tbl_data != '0);
  assign tbl_idx   = (st_q == S_TOG) ? CAL_SLOT : idx_q;
  assign in_wait   = (st_q == S_TOG_WAIT) || (st_q == S_POLL_WAIT);
  assign tmr_go    = in_wait && !tmr_busy;
  assign ofs_pinned = (code_q == 4'h0) || (code_q == 4'hF);

  // access selection
  always_comb begin
    acc = 1'b0; acc_we = 1'b0; acc_addr = '0; acc_wdata = '0;
    unique case (st_q)
      S_TBL_WR:  begin acc = 1'b1; acc_we = 1'b1; acc_addr = e_addr; acc_wdata = e_data; end
      S_TBL_RD:  begin acc = 1'b1; acc_addr = A_AMP; end
      S_TBL_RMW: begin acc = 1'b1; acc_we = 1'b1; acc_addr = A_AMP;
                       acc_wdata = amp_merge(tmp_q, amp_coarse, trim_fuse); end
      S_TOG_RD:  begin acc = 1'b1; acc_addr = A_CAL; end
      S_TOG_LO:  begin acc = 1'b1; acc_we = 1'b1; acc_addr = A_CAL; acc_wdata = base_q & ~CAL_BIT; end
      S_TOG_HI:  begin acc = 1'b1; acc_we = 1'b1; acc_addr = A_CAL; acc_wdata = base_q | CAL_BIT; end
      S_DBG_RD0: begin acc = 1'b1; acc_addr = A_DBG0; end
      S_DBG_RD1: begin acc = 1'b1; acc_addr = A_DBG1; end
      S_DBG_WR0: begin acc = 1'b1; acc_we = 1'b1; acc_addr = A_DBG0; acc_wdata = sv0_q | DBG0_SET; end
      S_DBG_WR1: begin acc = 1'b1; acc_we = 1'b1; acc_addr = A_DBG1;
                       acc_wdata = (sv1_q & ~DBG1_MASK) | DBG1_VALUE; end
      S_POLL_RD: begin acc = 1'b1; acc_addr = A_POLL; end
      S_RST0:    begin acc = 1'b1; acc_we = 1'b1; acc_addr = A_DBG0; acc_wdata = sv0_q; end
      S_RST1:    begin acc = 1'b1; acc_we = 1'b1; acc_addr = A_DBG1; acc_wdata = sv1_q; end
      S_OFS_RDC: begin acc = 1'b1; acc_addr = A_CODE; end
      S_OFS_RDR: begin acc = 1'b1; acc_addr = A_RNG; end
      S_OFS_WR:  begin acc = 1'b1; acc_we = 1'b1; acc_addr = A_RNG;
                       acc_wdata = {tmp_q[15:4], tmp_q[3:2] + 2'd1, tmp_q[1:0]}; end
      default: ;
    endcase
  end

  // next state
  always_comb begin
    st_d = st_q; idx_d = idx_q; base_d = base_q; base_ok_d = base_ok_q;
    sv0_d = sv0_q; sv1_d = sv1_q; tmp_d = tmp_q; code_d = code_q;
    pcnt_d = pcnt_q; fail_d = fail_q;
    unique case (st_q)
      S_IDLE: if (start) begin
        idx_d = '0; base_ok_d = 1'b0; fail_d = 1'b0;
        st_d  = cfg_load_tbl ? S_TBL : S_TOG;
      end
      S_TBL: begin
        if (idx_q == LAST_IDX) st_d = S_TOG;
        else if (e_rmw)        st_d = S_TBL_RD;
        else if (e_wr)         st_d = S_TBL_WR;
        else                   idx_d = idx_q + 1'b1;
      end
      S_TBL_WR, S_TBL_RMW: if (xdone) begin
        idx_d = idx_q + 1'b1; st_d = S_TBL;
      end
      S_TBL_RD: if (xdone) begin tmp_d = reg_rdata; st_d = S_TBL_RMW; end
      S_TOG: begin
        if (!tgl_en)        st_d = after_tog;
        else if (base_ok_q) st_d = S_TOG_LO;
        else if (slot_full) begin base_d = tbl_data; base_ok_d = 1'b1; st_d = S_TOG_LO; end
        else                st_d = S_TOG_RD;
      end
      S_TOG_RD: if (xdone) begin base_d = reg_rdata; base_ok_d = 1'b1; st_d = S_TOG_LO; end
      S_TOG_LO:   if (xdone)   st_d = S_TOG_WAIT;
      S_TOG_WAIT: if (tmr_exp) st_d = S_TOG_HI;
      S_TOG_HI:   if (xdone)   st_d = after_tog;
      S_DBG_RD0:  if (xdone) begin sv0_d = reg_rdata; st_d = S_DBG_RD1; end
      S_DBG_RD1:  if (xdone) begin sv1_d = reg_rdata; st_d = S_DBG_WR0; end
      S_DBG_WR0:  if (xdone) st_d = S_DBG_WR1;
      S_DBG_WR1:  if (xdone) begin pcnt_d = '0; st_d = S_POLL_RD; end
      S_POLL_RD: if (xdone) begin
        if (reg_rdata[15])                 st_d = S_RST0;
        else if (pcnt_q == PCW'(POLL_MAX)) begin fail_d = 1'b1; st_d = S_RST0; end
        else                               st_d = S_POLL_WAIT;
      end
      S_POLL_WAIT: if (tmr_exp) begin pcnt_d = pcnt_q + 1'b1; st_d = S_POLL_RD; end
      S_RST0: if (xdone) st_d = S_RST1;
      S_RST1: if (xdone) st_d = after_dbg;
      S_OFS_RDC: if (xdone) begin code_d = reg_rdata[4:1]; st_d = S_OFS_RDR; end
      S_OFS_RDR: if (xdone) begin
        tmp_d = reg_rdata;
        st_d  = (ofs_pinned && (reg_rdata[3:2] != 2'b11)) ? S_OFS_WR : S_FIN;
      end
      S_OFS_WR: if (xdone) st_d = S_TOG;
      S_FIN:    st_d = S_IDLE;
      default:  st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE; idx_q <= '0; base_q <= '0; base_ok_q <= 1'b0;
      sv0_q <= '0; sv1_q <= '0; tmp_q <= '0; code_q <= '0;
      pcnt_q <= '0; fail_q <= 1'b0;
    end else begin
      st_q <= st_d; idx_q <= idx_d; base_q <= base_d; base_ok_q <= base_ok_d;
      sv0_q <= sv0_d; sv1_q <= sv1_d; tmp_q <= tmp_d; code_q <= code_d;
      pcnt_q <= pcnt_d; fail_q <= fail_d;
    end
  end

  assign done = (st_q == S_FIN);
  assign fail = fail_q;

endmodule

// File: rtl/phycal_seq_chk.sv
module phycal_seq_chk #(
  parameter int DLY_CYC = 50000
) (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_req,
  input logic        reg_we,
  input logic [5:0]  reg_addr,
  input logic [15:0] reg_wdata,
  input logic        reg_ack,
  input logic [15:0] reg_rdata,
  input logic        done,
  input logic        fail
);

  logic [31:0] gap;
  logic        lo_seen;
  logic        cal_wr;

  assign cal_wr = reg_req && reg_ack && reg_we && (reg_addr == 6'h09);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap     <= '0;
      lo_seen <= 1'b0;
    end else if (cal_wr && !reg_wdata[9]) begin
      gap     <= 32'd1;
      lo_seen <= 1'b1;
    end else if (gap != 32'hFFFF_FFFF) begin
      gap <= gap + 32'd1;
    end
  end

  assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_req && !reg_ack) |=> (reg_req && $stable(reg_addr) && $stable(reg_we) && $stable(reg_wdata)));

  assert_req_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(reg_req) |-> $past(reg_ack));

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !reg_req);

  assert_fail_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fail) |-> $past(reg_req && reg_ack && !reg_we && (reg_addr == 6'h30) && !reg_rdata[15]));

  assert_cal_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_wr && reg_wdata[9] && lo_seen) |-> (gap >= 32'(DLY_CYC)));

endmodule

bind phycal_seq phycal_seq_chk #(.DLY_CYC(DLY_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_req(reg_req), .reg_we(reg_we),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_ack(reg_ack),
  .reg_rdata(reg_rdata), .done(done), .fail(fail)
);

// File: tb/tb_phycal_seq.sv
module tb_phycal_seq;

  localparam int CLK_PERIOD = 10;
  localparam int DLY        = 20;
  localparam int PMAX       = 10;
  localparam int WD_CYCLES  = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        cfg_load_tbl = 1'b0, cfg_cal_pulse = 1'b0, cfg_dbg_poll = 1'b0, cfg_ofs_fix = 1'b0;
  logic [3:0]  trim_fuse = 4'd0;
  logic [7:0]  amp_coarse = 8'hFF;
  logic [15:0] amp_fine = 16'hFFFF;
  logic [5:0]  tbl_idx, tbl_addr;
  logic [15:0] tbl_data;
  logic        reg_req, reg_we, reg_ack;
  logic [5:0]  reg_addr;
  logic [15:0] reg_wdata, reg_rdata;
  logic        done, fail;

  always #(CLK_PERIOD/2) clk = ~clk;

  phycal_seq #(.TBL_DEPTH(48), .DLY_CYC(DLY), .POLL_MAX(PMAX)) dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cfg_load_tbl(cfg_load_tbl), .cfg_cal_pulse(cfg_cal_pulse),
    .cfg_dbg_poll(cfg_dbg_poll), .cfg_ofs_fix(cfg_ofs_fix),
    .trim_fuse(trim_fuse), .amp_coarse(amp_coarse), .amp_fine(amp_fine),
    .tbl_idx(tbl_idx), .tbl_addr(tbl_addr), .tbl_data(tbl_data),
    .reg_req(reg_req), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_ack(reg_ack), .reg_rdata(reg_rdata),
    .done(done), .fail(fail)
  );

  // table
  logic [5:0]  ta [48];
  logic [15:0] td [48];
  assign tbl_addr = (tbl_idx < 6'd48) ? ta[tbl_idx] : 6'd0;
  assign tbl_data = (tbl_idx < 6'd48) ? td[tbl_idx] : 16'd0;

  // behavioural PHY register model
  logic [15:0] pre  [64];
  logic [15:0] phy  [64];
  int          rdc  [64];
  int          poll_after = 1;
  logic        ld = 1'b0;

  always @(posedge clk) begin
    if (ld) begin
      for (int i = 0; i < 64; i++) begin
        phy[i] <= pre[i];
        rdc[i] <= 0;
      end
      reg_ack <= 1'b0;
    end else if (reg_req && !reg_ack) begin
      reg_ack <= 1'b1;
      if (reg_we) phy[reg_addr] <= reg_wdata;
      else begin
        rdc[reg_addr] <= rdc[reg_addr] + 1;
        if (reg_addr == 6'h30)
          reg_rdata <= ((rdc[48] + 1) >= poll_after) ? 16'h8000 : 16'h0000;
        else
          reg_rdata <= phy[reg_addr];
      end
    end else begin
      reg_ack <= 1'b0;
    end
  end

  // scoreboard
  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int lo_cyc = 0;
  logic [21:0] q [$];
  logic [5:0]  cap_a;
  logic [15:0] cap_d;
  logic        cap_we;
  logic        prev_req = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic ex(input logic [5:0] a, input logic [15:0] d);
    q.push_back({a, d});
  endtask

  task automatic ex_tog(input logic [15:0] b);
    ex(6'h09, b & ~16'h0200);
    ex(6'h09, b | 16'h0200);
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (reg_req && !prev_req) begin
        cap_a = reg_addr; cap_d = reg_wdata; cap_we = reg_we;
      end
      if (reg_req && reg_ack) begin
        chk((cap_a == reg_addr) && (cap_we == reg_we) && (!reg_we || cap_d == reg_wdata),
            "R3", "request fields held", {26'd0, reg_addr}, {26'd0, cap_a});
        if (reg_we) begin
          if (q.size() == 0) begin
            chk(1'b0, "R2", "unexpected write", {10'd0, reg_addr, reg_wdata}, 32'd0);
          end else begin
            logic [21:0] e;
            e = q.pop_front();
            chk({reg_addr, reg_wdata} == e, "R2", "write order/value",
                {10'd0, reg_addr, reg_wdata}, {10'd0, e});
          end
          if (reg_addr == 6'h09 && !reg_wdata[9]) lo_cyc = cyc;
          if (reg_addr == 6'h09 && reg_wdata[9] && lo_cyc != 0)
            chk((cyc - lo_cyc) >= DLY, "R4", "pulse gap", cyc - lo_cyc, DLY);
        end
      end
      prev_req = reg_req;
    end
  end

  task automatic loadm();
    @(negedge clk) ld = 1'b1;
    @(negedge clk) ld = 1'b0;
  endtask

  task automatic clr_tbl();
    for (int i = 0; i < 48; i++) begin ta[i] = 6'd0; td[i] = 16'd0; end
  endtask

  task automatic run(input string tag);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk(fail == 1'b0, "R7", {tag, " fail cleared by start"}, fail, 0);
    while (!done) @(negedge clk);
    @(negedge clk);
    chk(done == 1'b0, "R10", {tag, " done one cycle"}, done, 0);
    chk(q.size() == 0, "R2", {tag, " all expected writes seen"}, q.size(), 0);
  endtask

  // watchdog
  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    checks++; errors++;
    $display("FAIL R10 watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] r;
    for (int i = 0; i < 64; i++) pre[i] = 16'h1000 + 16'(i);
    clr_tbl();
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(done == 1'b0 && fail == 1'b0 && reg_req == 1'b0, "R1", "reset outputs",
        {29'd0, done, fail, reg_req}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(reg_req == 1'b0, "R1", "idle without start", reg_req, 0);
    loadm();

    // S2: full table with holes, pulse only (R2, R4)
    for (int i = 0; i < 48; i++) begin
      if (i % 5 == 3) begin ta[i] = 6'd0; td[i] = 16'd0; end
      else begin ta[i] = 6'(i); td[i] = 16'(i * 16'h0111) ^ 16'h00A5; end
    end
    for (int i = 0; i < 48; i++) if (ta[i] != 0 || td[i] != 0) ex(ta[i], td[i]);
    ex_tog(td[9]);
    cfg_load_tbl = 1'b1; cfg_cal_pulse = 1'b1;
    run("S2");
    chk(rdc[9] == 0, "R4", "slot 9 used, no read of 0x09", rdc[9], 0);

    // S3: sparse table, RMW of 0x20, fine override, read base (R5, R4)
    clr_tbl(); loadm();
    ta[1] = 6'h01; td[1] = 16'hAC86;
    ta[6] = 6'h06; td[6] = 16'h0003;
    trim_fuse = 4'd3; amp_coarse = 8'h5A; amp_fine = 16'h1234;
    ex(6'h01, 16'hAC86); ex(6'h06, 16'h0003);
    ex(6'h20, 16'h108A);
    ex(6'h21, 16'h1234);
    ex_tog(pre[9]);
    run("S3");
    chk(rdc[32] == 1, "R5", "one read of 0x20", rdc[32], 1);
    chk(rdc[9] == 1, "R4", "one read of 0x09", rdc[9], 1);

    // S4: occupied slot 32, trim 0xC kept, no pulse (R5, R4)
    clr_tbl(); loadm();
    ta[32] = 6'h20; td[32] = 16'h947A;
    trim_fuse = 4'hC; amp_coarse = 8'hFF; amp_fine = 16'hFFFF;
    cfg_cal_pulse = 1'b0;
    ex(6'h20, 16'h94CA);
    run("S4");
    chk(rdc[32] == 0, "R5", "no read for occupied slot", rdc[32], 0);

    // S5: no table, debug poll succeeds on third read (R6, R7, R8, R2)
    clr_tbl(); trim_fuse = 4'd0; loadm();
    cfg_load_tbl = 1'b0; cfg_dbg_poll = 1'b1; poll_after = 3;
    ex_tog(pre[9]);
    ex(6'h0D, 16'h104D);
    ex(6'h10, 16'h13C0);
    ex(6'h0D, 16'h100D);
    ex(6'h10, 16'h1010);
    run("S5");
    chk(rdc[48] == 3, "R7", "poll reads until set", rdc[48], 3);
    chk(fail == 1'b0, "R7", "no fail on success", fail, 0);

    // S6: poll never completes (R7, R8)
    loadm(); poll_after = 1000;
    ex_tog(pre[9]);
    ex(6'h0D, 16'h104D); ex(6'h10, 16'h13C0);
    ex(6'h0D, 16'h100D); ex(6'h10, 16'h1010);
    run("S6");
    chk(rdc[48] == PMAX + 1, "R7", "poll read limit", rdc[48], PMAX + 1);
    chk(fail == 1'b1, "R7", "fail set on timeout", fail, 1);
    repeat (3) @(negedge clk);
    chk(fail == 1'b1, "R7", "fail sticky", fail, 1);

    // S7: offset pinned low, range widened three times (R9)
    cfg_dbg_poll = 1'b0; cfg_cal_pulse = 1'b1; cfg_ofs_fix = 1'b1;
    pre[31] = 16'h0001; pre[11] = 16'hA901; loadm();
    r = pre[11];
    ex_tog(pre[9]);
    while (r[3:2] != 2'b11) begin
      r[3:2] = r[3:2] + 2'd1;
      ex(6'h0B, r);
      ex_tog(pre[9]);
    end
    run("S7");
    chk(rdc[31] == 4, "R9", "code reads", rdc[31], 4);
    chk(rdc[9] == 1, "R4", "base read once across retries", rdc[9], 1);

    // S8: code mid-range, no update (R9)
    pre[31] = 16'h0006; pre[11] = 16'h0000; loadm();
    ex_tog(pre[9]);
    run("S8");
    chk(rdc[11] == 1, "R9", "single range read", rdc[11], 1);

    // S9: code all ones but range full, suppressed (R9)
    pre[31] = 16'h001E; pre[11] = 16'h000C; loadm();
    ex_tog(pre[9]);
    run("S9");
    chk(phy[11] == 16'h000C, "R9", "range unchanged", phy[11], 16'h000C);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule